// File: doc/BRIEF.md
# Matrix Accelerator Controller

This block sits between a host processor and a small matrix-product engine. The host programs three base addresses through a four-word register port: one for the left operand, one for the right operand, and one for the product. The block then runs the whole job without further help. It fetches both 8x8 operand matrices from their own memories, runs the multiply-accumulate engine, and stores the 8x8 product in a third memory. It reports progress through a status word.

The host starts a job by writing a new value to the product-base register. Operand bases are written first and never start anything on their own. A ten-state sequencer orders the phases: operand A fetch, operand B fetch, compute, and write-back. Each fetch or store phase streams one word per cycle against memories with one cycle of read latency. A start request that arrives while a job runs is remembered and launched as soon as the running job finishes. Each job works on the bases captured at its own start.

Top module: `mxa_ctrl`

## Requirements
- R1: After reset the status word reads 0, all three base registers read 0, and `a_rd_en`, `b_rd_en` and `c_wr_en` are low.
- R2: The host reads register offsets 0 (A base), 1 (B base) and 2 (product base) back as last written. Offset 3 is the status word: bit 0 is busy, bit 1 is done, and every other bit reads 0. `host_rdata` shows the register selected by `host_addr` one clock after the address is presented.
- R3: A write to offset 2 whose data differs from the value held there starts a job. A write of the same value to offset 2 starts nothing, and writes to offsets 0 or 1 start nothing.
- R4: A job first issues 64 reads of A on consecutive cycles at A base + 0 … +63. It then issues 64 reads of B in the same way. Read data is taken one cycle after each request.
- R5: Product element (i,j) is stored at index i*8+j and equals the unsigned sum over k of A[i*8+k]·B[k*8+j]. It is computed at the full 40-bit result width without overflow.
- R6: Write-back issues 64 writes on consecutive cycles to product base + 0 … +63. No write is ever issued in the same cycle as an operand read.
- R7: Busy is set from the cycle after a start until completion. Done is set only after the last write-back. Busy and done are never both set, and done clears when the next job starts.
- R8: A start write made while busy updates the register that reads back at once. It does not disturb the running job, and a new job starts right after the running one completes.
- R9: Each job uses the base addresses captured at its own start. Base writes made during the job do not move its transfers.
- R10: Transfer addresses wrap modulo 2^16 when base + index passes 0xFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_we | input | 1 | Host register write strobe |
| host_addr | input | 2 | Host register offset |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Registered read data for `host_addr` |
| a_rd_en | output | 1 | Operand A memory read request |
| a_addr | output | 16 | Operand A memory address |
| a_rdata | input | 16 | Operand A memory data, one cycle after request |
| b_rd_en | output | 1 | Operand B memory read request |
| b_addr | output | 16 | Operand B memory address |
| b_rdata | input | 16 | Operand B memory data, one cycle after request |
| c_wr_en | output | 1 | Product memory write strobe |
| c_addr | output | 16 | Product memory address |
| c_wdata | output | 40 | Product memory write data |

## Verification
The product path is tried with four operand patterns:
- An identity left operand shows whether row and column indices are swapped or shifted.
- All-ones operands at full scale show whether the 40-bit accumulation truncates.
- A ramp against a scaled ramp catches a wrong k-ordering in the accumulation.
- A hashed pattern breaks any symmetry that could hide a transposition.

A further case places the product window across the top of the address space, so a carry lost in the address adder shows up. Directed tests then check three things: that writes to the non-starting offsets and a repeated write of the same product base are ignored, that a second start issued mid-job is deferred and not lost, and that the running job keeps its captured operand base.

// File: rtl/mxa_pkg.sv
package mxa_pkg;
  typedef enum logic [3:0] {
    S_IDLE, S_LDA_REQ, S_LDA_WAIT, S_LDB_REQ, S_LDB_WAIT,
    S_CMP_GO, S_CMP_WAIT, S_ST_REQ, S_ST_WAIT, S_DONE
  } seq_state_e;

  localparam logic [1:0] OFS_A    = 2'd0;
  localparam logic [1:0] OFS_B    = 2'd1;
  localparam logic [1:0] OFS_C    = 2'd2;
  localparam logic [1:0] OFS_STAT = 2'd3;

  localparam int ST_BUSY_BIT = 0;
  localparam int ST_DONE_BIT = 1;
endpackage

// File: rtl/mxa_regfile.sv
module mxa_regfile
  import mxa_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [1:0]    addr,
  input  logic [AW-1:0] wdata,
  output logic [AW-1:0] rdata,
  input  logic          busy,
  input  logic          done,
  output logic [AW-1:0] a_base,
  output logic [AW-1:0] b_base,
  output logic [AW-1:0] c_base,
  output logic          start_req,
  input  logic          start_ack
);
  logic [AW-1:0] status_w;
  logic          trig_w;

  always_comb begin
    status_w = '0;
    status_w[ST_BUSY_BIT] = busy;
    status_w[ST_DONE_BIT] = done;
  end

  // a changed product base is the only start trigger
  assign trig_w = we && (addr == OFS_C) && (wdata != c_base);

  always_ff @(posedge clk) begin
    if (rst) begin
      a_base    <= '0;
      b_base    <= '0;
      c_base    <= '0;
      start_req <= 1'b0;
      rdata     <= '0;
    end else begin
      if (we) begin
        case (addr)
          OFS_A:   a_base <= wdata;
          OFS_B:   b_base <= wdata;
          OFS_C:   c_base <= wdata;
          default: ;
        endcase
      end
      if (trig_w)         start_req <= 1'b1;
      else if (start_ack) start_req <= 1'b0;
      case (addr)
        OFS_A:   rdata <= a_base;
        OFS_B:   rdata <= b_base;
        OFS_C:   rdata <= c_base;
        default: rdata <= status_w;
      endcase
    end
  end

  // R3
  start_src_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(start_req) |-> $past(we && (addr == OFS_C)));

  // R8
  start_held_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && start_req) |=> start_req);
endmodule

// File: rtl/mxa_engine.sv
module mxa_engine #(
  parameter int N     = 8,
  parameter int DW    = 16,
  parameter int ACC_W = 40
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         ld_a_we,
  input  logic                         ld_b_we,
  input  logic [$clog2(N*N)-1:0]       ld_idx,
  input  logic [DW-1:0]                ld_data,
  input  logic                         go,
  output logic                         cmp_done,
  input  logic [$clog2(N*N)-1:0]       rd_idx,
  output logic [ACC_W-1:0]             rd_data
);
  localparam int NE = N * N;
  localparam int IW = $clog2(NE);
  localparam int KW = $clog2(N);
  localparam logic [KW-1:0] KLAST = KW'(N - 1);

  logic [DW-1:0]    a_mem [NE];
  logic [DW-1:0]    b_mem [NE];
  logic [ACC_W-1:0] c_mem [NE];

  logic             running;
  logic [KW-1:0]    row, col, kk;
  logic [ACC_W-1:0] acc_q, prod_w, acc_n;
  logic [IW-1:0]    a_ix, b_ix, c_ix;

  always_ff @(posedge clk) begin
    if (ld_a_we) a_mem[ld_idx] <= ld_data;
    if (ld_b_we) b_mem[ld_idx] <= ld_data;
  end

  assign a_ix   = IW'(int'(row) * N + int'(kk));
  assign b_ix   = IW'(int'(kk) * N + int'(col));
  assign c_ix   = IW'(int'(row) * N + int'(col));
  assign prod_w = ACC_W'(a_mem[a_ix]) * ACC_W'(b_mem[b_ix]);
  assign acc_n  = (kk == '0) ? prod_w : acc_q + prod_w;
  assign rd_data = c_mem[rd_idx];

  always_ff @(posedge clk) begin
    if (running && kk == KLAST) c_mem[c_ix] <= acc_n;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      running  <= 1'b0;
      cmp_done <= 1'b0;
      row      <= '0;
      col      <= '0;
      kk       <= '0;
      acc_q    <= '0;
    end else begin
      cmp_done <= 1'b0;
      if (go) begin
        running <= 1'b1;
        row     <= '0;
        col     <= '0;
        kk      <= '0;
      end else if (running) begin
        acc_q <= acc_n;
        if (kk == KLAST) begin
          kk <= '0;
          if (col == KLAST) begin
            col <= '0;
            if (row == KLAST) begin
              running  <= 1'b0;
              cmp_done <= 1'b1;
            end else begin
              row <= row + 1'b1;
            end
          end else begin
            col <= col + 1'b1;
          end
        end else begin
          kk <= kk + 1'b1;
        end
      end
    end
  end

  // R5
  go_idle_chk: assert property (@(posedge clk) disable iff (rst)
    go |-> !running);

  // R5
  run_src_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(running) |-> $past(go));
endmodule

// File: rtl/mxa_sequencer.sv
module mxa_sequencer
  import mxa_pkg::*;
#(
  parameter int N     = 8,
  parameter int AW    = 16,
  parameter int DW    = 16,
  parameter int ACC_W = 40
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   start_req,
  output logic                   start_ack,
  input  logic [AW-1:0]          a_base_in,
  input  logic [AW-1:0]          b_base_in,
  input  logic [AW-1:0]          c_base_in,
  output logic                   busy,
  output logic                   done,
  output logic                   a_rd_en,
  output logic [AW-1:0]          a_addr,
  input  logic [DW-1:0]          a_rdata,
  output logic                   b_rd_en,
  output logic [AW-1:0]          b_addr,
  input  logic [DW-1:0]          b_rdata,
  output logic                   c_wr_en,
  output logic [AW-1:0]          c_addr,
  output logic [ACC_W-1:0]       c_wdata,
  output logic                   eng_a_we,
  output logic                   eng_b_we,
  output logic [$clog2(N*N)-1:0] eng_idx,
  output logic [DW-1:0]          eng_wdata,
  output logic                   eng_go,
  input  logic                   eng_done,
  output logic [$clog2(N*N)-1:0] eng_rd_idx,
  input  logic [ACC_W-1:0]       eng_rd_data
);
  localparam int NE = N * N;
  localparam int IW = $clog2(NE);
  localparam logic [IW-1:0] CLAST = IW'(NE - 1);

  seq_state_e    state;
  logic [IW-1:0] cnt;
  logic [IW-1:0] iss_idx, cap_idx;
  logic          a_cap, b_cap;
  logic [AW-1:0] a_b, b_b, c_b;

  assign start_ack  = (state == S_IDLE) && start_req;
  assign eng_a_we   = a_cap;
  assign eng_b_we   = b_cap;
  assign eng_idx    = cap_idx;
  assign eng_wdata  = a_cap ? a_rdata : b_rdata;
  assign eng_rd_idx = cnt;

  // read-return pipeline: data arrives one cycle after the request
  always_ff @(posedge clk) begin
    if (rst) begin
      a_cap   <= 1'b0;
      b_cap   <= 1'b0;
      cap_idx <= '0;
    end else begin
      a_cap   <= a_rd_en;
      b_cap   <= b_rd_en;
      cap_idx <= iss_idx;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= S_IDLE;
      cnt     <= '0;
      iss_idx <= '0;
      a_b     <= '0;
      b_b     <= '0;
      c_b     <= '0;
      busy    <= 1'b0;
      done    <= 1'b0;
      a_rd_en <= 1'b0;
      b_rd_en <= 1'b0;
      c_wr_en <= 1'b0;
      a_addr  <= '0;
      b_addr  <= '0;
      c_addr  <= '0;
      c_wdata <= '0;
      eng_go  <= 1'b0;
    end else begin
      a_rd_en <= 1'b0;
      b_rd_en <= 1'b0;
      c_wr_en <= 1'b0;
      eng_go  <= 1'b0;
      case (state)
        S_IDLE: begin
          if (start_req) begin
            a_b   <= a_base_in;
            b_b   <= b_base_in;
            c_b   <= c_base_in;
            busy  <= 1'b1;
            done  <= 1'b0;
            cnt   <= '0;
            state <= S_LDA_REQ;
          end
        end
        S_LDA_REQ: begin
          a_rd_en <= 1'b1;
          a_addr  <= a_b + AW'(cnt);
          iss_idx <= cnt;
          cnt     <= cnt + 1'b1;
          if (cnt == CLAST) state <= S_LDA_WAIT;
        end
        S_LDA_WAIT: begin
          if (!a_rd_en && !a_cap) state <= S_LDB_REQ;
        end
        S_LDB_REQ: begin
          b_rd_en <= 1'b1;
          b_addr  <= b_b + AW'(cnt);
          iss_idx <= cnt;
          cnt     <= cnt + 1'b1;
          if (cnt == CLAST) state <= S_LDB_WAIT;
        end
        S_LDB_WAIT: begin
          if (!b_rd_en && !b_cap) state <= S_CMP_GO;
        end
        S_CMP_GO: begin
          eng_go <= 1'b1;
          state  <= S_CMP_WAIT;
        end
        S_CMP_WAIT: begin
          if (eng_done) begin
            cnt   <= '0;
            state <= S_ST_REQ;
          end
        end
        S_ST_REQ: begin
          c_wr_en <= 1'b1;
          c_addr  <= c_b + AW'(cnt);
          c_wdata <= eng_rd_data;
          cnt     <= cnt + 1'b1;
          if (cnt == CLAST) state <= S_ST_WAIT;
        end
        S_ST_WAIT: state <= S_DONE;
        S_DONE: begin
          busy  <= 1'b0;
          done  <= 1'b1;
          state <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R6
  rw_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(c_wr_en && (a_rd_en || b_rd_en)));

  // R4
  a_step_chk: assert property (@(posedge clk) disable iff (rst)
    (a_rd_en && $past(a_rd_en)) |-> (a_addr == AW'($past(a_addr) + 1'b1)));

  // R6
  c_step_chk: assert property (@(posedge clk) disable iff (rst)
    (c_wr_en && $past(c_wr_en)) |-> (c_addr == AW'($past(c_addr) + 1'b1)));

  // R7
  busy_done_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(busy && done));

  // R7
  done_after_store_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> $past(c_wr_en, 2));

  // R3
  busy_src_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(start_req));
endmodule

// File: rtl/mxa_ctrl.sv
module mxa_ctrl
  import mxa_pkg::*;
#(
  parameter int N     = 8,
  parameter int AW    = 16,
  parameter int DW    = 16,
  parameter int ACC_W = 40
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             host_we,
  input  logic [1:0]       host_addr,
  input  logic [AW-1:0]    host_wdata,
  output logic [AW-1:0]    host_rdata,
  output logic             a_rd_en,
  output logic [AW-1:0]    a_addr,
  input  logic [DW-1:0]    a_rdata,
  output logic             b_rd_en,
  output logic [AW-1:0]    b_addr,
  input  logic [DW-1:0]    b_rdata,
  output logic             c_wr_en,
  output logic [AW-1:0]    c_addr,
  output logic [ACC_W-1:0] c_wdata
);
  localparam int IW = $clog2(N * N);

  logic [AW-1:0]    a_base, b_base, c_base;
  logic             start_req, start_ack, busy, done;
  logic             eng_a_we, eng_b_we, eng_go, eng_done;
  logic [IW-1:0]    eng_idx, eng_rd_idx;
  logic [DW-1:0]    eng_wdata;
  logic [ACC_W-1:0] eng_rd_data;

  mxa_regfile #(.AW(AW)) u_regs (
    .clk(clk), .rst(rst), .we(host_we), .addr(host_addr), .wdata(host_wdata),
    .rdata(host_rdata), .busy(busy), .done(done), .a_base(a_base),
    .b_base(b_base), .c_base(c_base), .start_req(start_req), .start_ack(start_ack)
  );

  mxa_sequencer #(.N(N), .AW(AW), .DW(DW), .ACC_W(ACC_W)) u_seq (
    .clk(clk), .rst(rst), .start_req(start_req), .start_ack(start_ack),
    .a_base_in(a_base), .b_base_in(b_base), .c_base_in(c_base),
    .busy(busy), .done(done),
    .a_rd_en(a_rd_en), .a_addr(a_addr), .a_rdata(a_rdata),
    .b_rd_en(b_rd_en), .b_addr(b_addr), .b_rdata(b_rdata),
    .c_wr_en(c_wr_en), .c_addr(c_addr), .c_wdata(c_wdata),
    .eng_a_we(eng_a_we), .eng_b_we(eng_b_we), .eng_idx(eng_idx),
    .eng_wdata(eng_wdata), .eng_go(eng_go), .eng_done(eng_done),
    .eng_rd_idx(eng_rd_idx), .eng_rd_data(eng_rd_data)
  );

  mxa_engine #(.N(N), .DW(DW), .ACC_W(ACC_W)) u_eng (
    .clk(clk), .rst(rst), .ld_a_we(eng_a_we), .ld_b_we(eng_b_we),
    .ld_idx(eng_idx), .ld_data(eng_wdata), .go(eng_go), .cmp_done(eng_done),
    .rd_idx(eng_rd_idx), .rd_data(eng_rd_data)
  );
endmodule

// File: tb/mxa_ctrl_test.sv
`timescale 1ns/1ps
module mxa_ctrl_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        host_we = 1'b0;
  logic [1:0]  host_addr = 2'd3;
  logic [15:0] host_wdata = '0;
  logic [15:0] host_rdata;
  logic        a_rd_en, b_rd_en, c_wr_en;
  logic [15:0] a_addr, b_addr, c_addr;
  logic [15:0] a_rdata = '0, b_rdata = '0;
  logic [39:0] c_wdata;

  always #2.5 clk = ~clk;

  mxa_ctrl uut (
    .clk(clk), .rst(rst), .host_we(host_we), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata),
    .a_rd_en(a_rd_en), .a_addr(a_addr), .a_rdata(a_rdata),
    .b_rd_en(b_rd_en), .b_addr(b_addr), .b_rdata(b_rdata),
    .c_wr_en(c_wr_en), .c_addr(c_addr), .c_wdata(c_wdata)
  );

  // simple synchronous memories, one cycle read latency
  logic [15:0] mem_a [256];
  logic [15:0] mem_b [256];
  logic [39:0] mem_c [256];
  always @(posedge clk) begin
    if (a_rd_en) a_rdata <= mem_a[a_addr[7:0]];
    if (b_rd_en) b_rdata <= mem_b[b_addr[7:0]];
    if (c_wr_en) mem_c[c_addr[7:0]] <= c_wdata;
  end

  int n_tests = 0, n_fail = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // burst monitor: channel 0 = A reads, 1 = B reads, 2 = product writes
  int          cyc = 0, mon_err = 0;
  logic        pv [3] = '{1'b0, 1'b0, 1'b0};
  logic [15:0] pa [3] = '{16'h0, 16'h0, 16'h0};
  logic [15:0] st [3] = '{16'h0, 16'h0, 16'h0};
  int          len [3] = '{0, 0, 0};
  int          last_len [3] = '{0, 0, 0};
  int          fc [3] = '{0, 0, 0};
  int          total [3] = '{0, 0, 0};
  logic [2:0]  en_v;
  logic [15:0] ad_v [3];

  always @(negedge clk) begin
    cyc++;
    en_v = {c_wr_en, b_rd_en, a_rd_en};
    ad_v[0] = a_addr; ad_v[1] = b_addr; ad_v[2] = c_addr;
    if (c_wr_en && (a_rd_en || b_rd_en)) mon_err++;
    for (int ch = 0; ch < 3; ch++) begin
      if (en_v[ch]) begin
        if (pv[ch]) begin
          if (ad_v[ch] != 16'(pa[ch] + 16'd1)) mon_err++;
          len[ch]++;
        end else begin
          len[ch] = 1; st[ch] = ad_v[ch]; fc[ch] = cyc;
        end
        pa[ch] = ad_v[ch];
        total[ch]++;
      end else if (pv[ch]) begin
        last_len[ch] = len[ch];
      end
      pv[ch] = en_v[ch];
    end
  end

  task automatic host_wr(input logic [1:0] ad, input logic [15:0] d);
    @(negedge clk);
    host_we = 1'b1; host_addr = ad; host_wdata = d;
    @(negedge clk);
    host_we = 1'b0; host_addr = 2'd3;
  endtask

  task automatic host_rd(input logic [1:0] ad, output logic [15:0] d);
    @(negedge clk);
    host_addr = ad;
    @(negedge clk);
    d = host_rdata;
  endtask

  task automatic wait_done(output bit ok);
    logic [15:0] s;
    ok = 0;
    for (int i = 0; i < 3000; i++) begin
      host_rd(2'd3, s);
      if (s[1]) begin ok = 1; break; end
    end
  endtask

  function automatic logic [15:0] gen(input int pat, input int m, input int i);
    case (pat)
      0: return (m == 0) ? (((i / 8) == (i % 8)) ? 16'd1 : 16'd0) : 16'(i * 5 + 3);
      1: return 16'hFFFF;
      2: return (m == 0) ? 16'(i + 1) : 16'((i * 3) & 255);
      default: return 16'(((i + m * 17) * 37 + 11) ^ ((i + m * 17) << 5));
    endcase
  endfunction

  task automatic load(input int pat, input logic [15:0] ab, input logic [15:0] bb);
    for (int i = 0; i < 64; i++) begin
      mem_a[8'(ab + 16'(i))] = gen(pat, 0, i);
      mem_b[8'(bb + 16'(i))] = gen(pat, 1, i);
    end
  endtask

  // reference product from the bench's own stimulus memories
  task automatic check_product(input logic [15:0] ab, input logic [15:0] bb,
                               input logic [15:0] cb, input string req);
    int bad = 0;
    logic [39:0] exp_v, act_v, e0, a0;
    e0 = '0; a0 = '0;
    for (int r = 0; r < 8; r++)
      for (int c = 0; c < 8; c++) begin
        exp_v = '0;
        for (int k = 0; k < 8; k++)
          exp_v += 40'(mem_a[8'(ab + 16'(r * 8 + k))]) * 40'(mem_b[8'(bb + 16'(k * 8 + c))]);
        act_v = mem_c[8'(cb + 16'(r * 8 + c))];
        if (act_v != exp_v && bad == 0) begin e0 = exp_v; a0 = act_v; end
        if (act_v != exp_v) bad++;
      end
    check(bad == 0, req, 64'(a0), 64'(e0));
  endtask

  // stimulus table: {pattern, A base, B base, product base}
  localparam int NC = 5;
  localparam logic [51:0] CASES [NC] = '{
    {4'd0, 16'h0000, 16'h0040, 16'h0040},
    {4'd1, 16'h0040, 16'h0080, 16'h0080},
    {4'd2, 16'h0080, 16'h00C0, 16'h00C0},
    {4'd3, 16'h00C0, 16'h0000, 16'h0000},
    {4'd2, 16'hFFF0, 16'h0040, 16'hFFE0}
  };

  initial begin
    logic [15:0] rv;
    bit ok;
    int t0, c0;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    check(!a_rd_en && !b_rd_en && !c_wr_en, "R1 strobes", {a_rd_en, b_rd_en, c_wr_en}, 0);
    host_rd(2'd3, rv); check(rv == 16'h0, "R1 status", rv, 0);
    host_rd(2'd2, rv); check(rv == 16'h0, "R1 product base", rv, 0);

    // R2 readback
    host_wr(2'd0, 16'h1234);
    host_wr(2'd1, 16'hABCD);
    host_rd(2'd0, rv); check(rv == 16'h1234, "R2 A base", rv, 16'h1234);
    host_rd(2'd1, rv); check(rv == 16'hABCD, "R2 B base", rv, 16'hABCD);
    // R3 writes to offsets 0/1 start nothing
    repeat (10) @(negedge clk);
    host_rd(2'd3, rv);
    check(rv == 16'h0 && total[0] == 0, "R3 no start on A/B write", rv, 0);

    foreach (CASES[ci]) begin
      int pat;
      logic [15:0] ab, bb, cb;
      pat = int'(CASES[ci][51:48]);
      ab = CASES[ci][47:32]; bb = CASES[ci][31:16]; cb = CASES[ci][15:0];
      load(pat, ab, bb);
      host_wr(2'd0, ab);
      host_wr(2'd1, bb);
      host_wr(2'd2, cb);
      host_rd(2'd3, rv);
      check(rv == 16'h1, "R7 busy after start, done cleared", rv, 1);
      wait_done(ok);
      check(ok, "R7 done reached", ok, 1);
      host_rd(2'd3, rv);
      check(rv == 16'h2, "R7 idle status after done", rv, 2);
      check(last_len[0] == 64 && st[0] == ab, "R4 A burst", {st[0], 16'(last_len[0])}, {ab, 16'd64});
      check(last_len[1] == 64 && st[1] == bb && fc[1] > fc[0] + 63, "R4 B burst after A",
            {st[1], 16'(last_len[1])}, {bb, 16'd64});
      check(last_len[2] == 64 && st[2] == cb, "R6 write-back burst", {st[2], 16'(last_len[2])}, {cb, 16'd64});
      check(mon_err == 0, "R6 contiguity/overlap", mon_err, 0);
      if (ci == 4) check(st[2] == 16'hFFE0 && st[0] == 16'hFFF0, "R10 wrap bases", st[2], 16'hFFE0);
      check_product(ab, bb, cb, (ci == 4) ? "R10 wrapped product" : "R5 product");
    end

    // R3 repeated product base does not start
    t0 = total[0];
    host_wr(2'd2, 16'hFFE0);
    repeat (10) @(negedge clk);
    host_rd(2'd3, rv);
    check(rv == 16'h2 && total[0] == t0, "R3 same value ignored", rv, 2);

    // R8 / R9 start while busy
    load(2, 16'h0000, 16'h0040);
    load(3, 16'h0080, 16'h0080);
    load(2, 16'h0000, 16'h0040);
    c0 = total[2];
    host_wr(2'd0, 16'h0000);
    host_wr(2'd1, 16'h0040);
    host_wr(2'd2, 16'h0010);
    repeat (20) @(negedge clk);
    host_wr(2'd0, 16'h0080);
    host_wr(2'd2, 16'h0090);
    host_rd(2'd2, rv); check(rv == 16'h0090, "R8 readback while busy", rv, 16'h0090);
    host_rd(2'd3, rv); check(rv == 16'h1, "R8 still busy", rv, 1);
    for (int i = 0; i < 4000 && total[2] < c0 + 128; i++) @(negedge clk);
    wait_done(ok);
    check(ok && total[2] == c0 + 128, "R8 deferred job ran", total[2] - c0, 128);
    check(st[0] == 16'h0080, "R8 second job A base", st[0], 16'h0080);
    check_product(16'h0000, 16'h0040, 16'h0010, "R9 first job kept its bases");
    check_product(16'h0080, 16'h0040, 16'h0090, "R8 second job product");

    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule